// File: doc/BRIEF.md
# Split-Section BCD Decade Counter

This block is a four-bit counter made of two sections. A divide-by-two section drives the low output bit. A divide-by-five section drives the three upper bits as a binary value from 0 to 4. When the first section advances the second, the four outputs together count in 8421 BCD from 0 to 9 and then wrap. Each section has its own count-enable input. Both enables are sampled on a single system clock, in place of separate section clocks.

Two input pairs override counting at once, without waiting for a clock edge. When both pins of the set pair are high, the output is nine. When both pins of the clear pair are high, the output is zero. The set pair wins if both pairs are active. Parameters add two build options. The first is a feedback clear: when the count reaches a chosen terminal state, the counter returns to zero, so the count length becomes shorter than ten. The second is a tens decade: a second decade advances each time the high bit of the units decade falls, which extends the range to 00–99.

Top module: `ripple_decade`

## Requirements
- R1: With the sections linked (LINK_SECTIONS=1), each cycle with `tick_a` high advances `q_units` one step through 0,1,…,9,0. `q_units` is the BCD value, with bit 0 from the divide-by-two section and bits 3:1 from the divide-by-five section. `q_units` never exceeds 9.
- R2: While `set9_a` and `set9_b` are both high, `q_units` reads 1001 in the same cycle, with no clock edge needed. This holds even when the clear pair is also fully high.
- R3: While `clr0_a` and `clr0_b` are both high and the set pair is not both high, `q_units` reads 0000 in the same cycle. Count enables have no effect during this time.
- R4: Counting continues when only one pin of a pair is high. In a cycle with no count enable and no active override, the output holds its value.
- R5: With the sections split (LINK_SECTIONS=0), `tick_a` toggles only bit 0, and `tick_b` alone steps bits 3:1 through 0,1,2,3,4,0.
- R6: With the feedback clear enabled (FB_CLEAR=1), the terminal state FB_STATE is never shown while the set pair is inactive. The register holds that state for one cycle, and the output reads 0000 during that cycle. A count enable in that cycle counts from zero, so continuous enables give a count modulo FB_STATE.
- R7: With TWO_DECADES=1, `q_tens` advances by one BCD step, 9 wrapping to 0, in the cycle after `q_units` bit 3 falls. The pair counts 00 to 99 and wraps to 00.
- R8: After reset, `q_units` and `q_tens` read 0000.
- R9: After the set pair is released, the counter holds nine. The next count enable takes it to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_a | input | 1 | Count enable of the divide-by-two section |
| tick_b | input | 1 | Count enable of the divide-by-five section (split mode only) |
| clr0_a | input | 1 | Clear-to-zero pair, first pin |
| clr0_b | input | 1 | Clear-to-zero pair, second pin |
| set9_a | input | 1 | Set-to-nine pair, first pin |
| set9_b | input | 1 | Set-to-nine pair, second pin |
| q_units | output | 4 | Units value, bit 3 high to bit 0 low |
| q_tens | output | 4 | Tens value (zero without the tens decade) |

## Verification
The assertions check these rules on every cycle:
- the BCD range of both outputs
- the same-cycle override values of the set and clear pairs
- holding with no enable
- the absence of the terminal state when feedback clear is on
- single BCD steps of the tens value

Only the bench scenarios can show the following:
- the exact order of the decade sequence
- the independent stepping of the split sections
- counting from zero through the feedback transient under continuous enables
- the full 00–99 roll of the two-decade build
- resuming from nine after a release

// File: rtl/ripple_decade.sv
module ripple_decade #(
  parameter bit         LINK_SECTIONS = 1'b1,
  parameter bit         FB_CLEAR      = 1'b0,
  parameter logic [3:0] FB_STATE      = 4'd9,
  parameter bit         TWO_DECADES   = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_a,
  input  logic       tick_b,
  input  logic       clr0_a,
  input  logic       clr0_b,
  input  logic       set9_a,
  input  logic       set9_b,
  output logic [3:0] q_units,
  output logic [3:0] q_tens
);

  localparam logic [2:0] QUINT_TOP = 3'd4;
  localparam logic [3:0] NINE      = 4'd9;

  logic       force9, force0;
  logic       qa_r;
  logic [2:0] quint_r;
  logic       fb_hit;
  logic       base_a;
  logic [2:0] base_q;
  logic       quint_step;
  logic       next_a;
  logic [2:0] next_q;

  assign force9 = set9_a & set9_b;
  assign force0 = clr0_a & clr0_b & ~force9;

  assign fb_hit = FB_CLEAR && ({quint_r, qa_r} == FB_STATE);

  assign base_a = fb_hit ? 1'b0 : qa_r;
  assign base_q = fb_hit ? 3'd0 : quint_r;

  assign quint_step = LINK_SECTIONS ? (tick_a & base_a) : tick_b;

  assign next_a = tick_a ? ~base_a : base_a;

  always_comb begin
    next_q = base_q;
    if (quint_step)
      next_q = (base_q >= QUINT_TOP) ? 3'd0 : 3'(base_q + 3'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qa_r    <= 1'b0;
      quint_r <= 3'd0;
    end else if (force9) begin
      qa_r    <= 1'b1;
      quint_r <= QUINT_TOP;
    end else if (force0) begin
      qa_r    <= 1'b0;
      quint_r <= 3'd0;
    end else begin
      qa_r    <= next_a;
      quint_r <= next_q;
    end
  end

  assign q_units = force9            ? NINE :
                   (force0 | fb_hit) ? 4'd0 : {quint_r, qa_r};

  generate
    if (TWO_DECADES) begin : g_tens
      logic [3:0] tens_r;
      logic       qd_prev;
      logic       tens_step;

      assign tens_step = qd_prev & ~q_units[3];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          tens_r  <= 4'd0;
          qd_prev <= 1'b0;
        end else begin
          qd_prev <= (force9 | force0) ? 1'b0 : q_units[3];
          if (force9)
            tens_r <= NINE;
          else if (force0)
            tens_r <= 4'd0;
          else if (tens_step)
            tens_r <= (tens_r >= NINE) ? 4'd0 : 4'(tens_r + 4'd1);
        end
      end

      assign q_tens = force9 ? NINE : force0 ? 4'd0 : tens_r;
    end else begin : g_no_tens
      assign q_tens = 4'd0;
    end
  endgenerate

endmodule

module ripple_decade_chk #(
  parameter bit         FB_CLEAR = 1'b0,
  parameter logic [3:0] FB_STATE = 4'd9
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_a,
  input logic       tick_b,
  input logic       clr0_a,
  input logic       clr0_b,
  input logic       set9_a,
  input logic       set9_b,
  input logic [3:0] q_units,
  input logic [3:0] q_tens
);

  logic f9, f0;
  assign f9 = set9_a && set9_b;
  assign f0 = clr0_a && clr0_b && !f9;

  p_bcd_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (q_units <= 4'd9) && (q_tens <= 4'd9));

  p_set_nine_r2: assert property (@(posedge clk) disable iff (!rst_n)
    f9 |-> (q_units == 4'd9));

  p_clear_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    f0 |-> (q_units == 4'd0));

  p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_a && !tick_b && !f9 && !f0) ##1 (!f9 && !f0) |-> $stable(q_units));

  p_no_terminal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (FB_CLEAR && !f9) |-> (q_units != FB_STATE));

  p_tens_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!f9 && !f0) ##1 (!f9 && !f0) |->
      (q_tens == $past(q_tens)) ||
      (q_tens == (($past(q_tens) == 4'd9) ? 4'd0 : 4'($past(q_tens) + 4'd1))));

endmodule

bind ripple_decade ripple_decade_chk #(
  .FB_CLEAR(FB_CLEAR),
  .FB_STATE(FB_STATE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_a(tick_a), .tick_b(tick_b),
  .clr0_a(clr0_a), .clr0_b(clr0_b), .set9_a(set9_a), .set9_b(set9_b),
  .q_units(q_units), .q_tens(q_tens)
);

// File: tb/test_ripple_decade.sv
module test_ripple_decade;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_a = 1'b0, tick_b = 1'b0;
  logic clr0_a = 1'b0, clr0_b = 1'b0, set9_a = 1'b0, set9_b = 1'b0;
  logic [3:0] u_main, t_main, u_split, t_split, u_mod9, t_mod9, u_pair, t_pair;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ripple_decade i_ripple_decade (
    .clk(clk), .rst_n(rst_n), .tick_a(tick_a), .tick_b(tick_b),
    .clr0_a(clr0_a), .clr0_b(clr0_b), .set9_a(set9_a), .set9_b(set9_b),
    .q_units(u_main), .q_tens(t_main));

  ripple_decade #(.LINK_SECTIONS(1'b0)) i_ripple_decade_split (
    .clk(clk), .rst_n(rst_n), .tick_a(tick_a), .tick_b(tick_b),
    .clr0_a(clr0_a), .clr0_b(clr0_b), .set9_a(set9_a), .set9_b(set9_b),
    .q_units(u_split), .q_tens(t_split));

  ripple_decade #(.FB_CLEAR(1'b1), .FB_STATE(4'd9)) i_ripple_decade_mod9 (
    .clk(clk), .rst_n(rst_n), .tick_a(tick_a), .tick_b(tick_b),
    .clr0_a(clr0_a), .clr0_b(clr0_b), .set9_a(set9_a), .set9_b(set9_b),
    .q_units(u_mod9), .q_tens(t_mod9));

  ripple_decade #(.TWO_DECADES(1'b1)) i_ripple_decade_pair (
    .clk(clk), .rst_n(rst_n), .tick_a(tick_a), .tick_b(tick_b),
    .clr0_a(clr0_a), .clr0_b(clr0_b), .set9_a(set9_a), .set9_b(set9_b),
    .q_units(u_pair), .q_tens(t_pair));

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick_a = 0; tick_b = 0;
    clr0_a = 0; clr0_b = 0; set9_a = 0; set9_b = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic pulse(input logic ta, input logic tb);
    @(negedge clk);
    tick_a = ta; tick_b = tb;
    @(negedge clk);
    tick_a = 1'b0; tick_b = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R8 main units", u_main, 0);
    check("R8 split units", u_split, 0);
    check("R8 mod9 units", u_mod9, 0);
    check("R8 pair units", u_pair, 0);
    check("R8 pair tens", t_pair, 0);
  endtask

  task automatic t_decade();
    do_reset();
    for (int n = 1; n <= 23; n++) begin
      pulse(1'b1, 1'b0);
      check("R1 decade step", u_main, n % 10);
    end
  endtask

  task automatic t_sections();
    do_reset();
    pulse(1'b1, 1'b0);
    check("R5 low bit toggles", u_split, 1);
    pulse(1'b0, 1'b1);
    check("R5 quint 1", u_split, 3);
    pulse(1'b0, 1'b1);
    check("R5 quint 2", u_split, 5);
    pulse(1'b0, 1'b1);
    check("R5 quint 3", u_split, 7);
    pulse(1'b0, 1'b1);
    check("R5 quint 4", u_split, 9);
    pulse(1'b0, 1'b1);
    check("R5 quint wrap", u_split, 1);
    pulse(1'b1, 1'b0);
    check("R5 low fall leaves quint", u_split, 0);
  endtask

  task automatic t_set9();
    do_reset();
    for (int n = 0; n < 3; n++) pulse(1'b1, 1'b0);
    @(negedge clk);
    set9_a = 1'b1; set9_b = 1'b1;
    #1;
    check("R2 nine same cycle", u_main, 9);
    clr0_a = 1'b1; clr0_b = 1'b1;
    #1;
    check("R2 set over clear", u_main, 9);
    @(negedge clk);
    check("R2 nine held", u_main, 9);
    set9_a = 1'b0; set9_b = 1'b0; clr0_a = 1'b0; clr0_b = 1'b0;
    @(negedge clk);
    check("R9 nine after release", u_main, 9);
    pulse(1'b1, 1'b0);
    check("R9 nine to zero", u_main, 0);
    pulse(1'b1, 1'b0);
    check("R9 then one", u_main, 1);
  endtask

  task automatic t_clear();
    do_reset();
    for (int n = 0; n < 5; n++) pulse(1'b1, 1'b0);
    check("R3 before clear", u_main, 5);
    @(negedge clk);
    clr0_a = 1'b1; clr0_b = 1'b1;
    #1;
    check("R3 zero same cycle", u_main, 0);
    pulse(1'b1, 1'b0);
    check("R3 tick ignored", u_main, 0);
    @(negedge clk);
    clr0_a = 1'b0; clr0_b = 1'b0;
    #1;
    check("R3 zero after release", u_main, 0);
    pulse(1'b1, 1'b0);
    check("R3 counts from zero", u_main, 1);
  endtask

  task automatic t_partial();
    do_reset();
    @(negedge clk);
    clr0_a = 1'b1; set9_b = 1'b1;
    for (int n = 0; n < 4; n++) pulse(1'b1, 1'b0);
    check("R4 single pins count", u_main, 4);
    repeat (3) @(negedge clk);
    check("R4 hold without tick", u_main, 4);
    clr0_a = 1'b0; set9_b = 1'b0;
  endtask

  task automatic t_trunc();
    do_reset();
    @(negedge clk);
    tick_a = 1'b1;
    for (int n = 1; n <= 20; n++) begin
      @(negedge clk);
      check("R6 modulo nine", u_mod9, n % 9);
    end
    tick_a = 1'b0;
    @(negedge clk);
    check("R6 hold after run", u_mod9, 20 % 9);
  endtask

  task automatic t_cascade();
    do_reset();
    for (int n = 1; n <= 101; n++) begin
      pulse(1'b1, 1'b0);
      @(negedge clk);
      check("R7 pair value", t_pair * 10 + u_pair, n % 100);
    end
  endtask

  initial begin
    t_reset();
    t_decade();
    t_sections();
    t_set9();
    t_clear();
    t_partial();
    t_trunc();
    t_cascade();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule